// File: doc/BRIEF.md
# Per-Sample Acquisition and Control Sequencer

This block paces a motor drive's control loop, one pass per sampling period. A rising edge on the sampling-rate input starts a pass. The sequencer pulses the current-converter start and the position-capture strobe in the same cycle, then waits for the converter to report completion. It registers the two converted phase currents and derives the third as the negated, saturated sum of the other two. In the following cycle it pulses the start of the speed-control datapath. When the datapath reports done, the sequencer registers the datapath's three inverter switching commands onto its switch outputs. Between updates the switch outputs hold their value.

Each stage has its own cycle budget. The conversion must finish within `ACQ_LIMIT` cycles. The compute stage, counted from the cycle after the conversion is accepted, must finish within `COMP_LIMIT` cycles. The default is 120 cycles, which is 3 µs at 40 MHz, kept below the inverter's dead time. If either budget runs out, the pass is abandoned, every switch is forced off, and a late flag is raised. A sampling edge that arrives while a pass is still running does not start a new pass and raises an overrun flag instead. Both flags clear when the next pass is accepted.

Top module: `sample_seq`

## Requirements
- R1: A pass starts only on a rising edge of `fs_tick_i` seen while the sequencer is idle; a level held high never starts a second pass.
- R2: In the cycle after the starting edge, `adc_start_o` and `enc_capture_o` are both high, each for exactly one cycle.
- R3: `ctl_start_o` is a one-cycle pulse that comes only after the conversion is accepted: it is low in the cycle after `adc_done_i` is taken and high in the cycle after that.
- R4: When `adc_done_i` is taken, `ia_o` and `ib_o` take `adc_ia_i` and `adc_ib_i` in the next cycle, and `ic_o` takes -(ia + ib) clamped to the signed W-bit range (default W=12, so -2048..2047). All three are two's complement.
- R5: When `ctl_done_i` is high during the compute wait, `sw_o` takes `sw_cmd_i` in the next cycle. Bit 0 drives switch 1, bit 1 switch 2, and bit 2 switch 3; a 1 means on.
- R6: `sw_o` changes only on an accepted compute result, an abort, or reset. A `ctl_done_i` pulse while the sequencer is idle has no effect.
- R7: A rising edge of `fs_tick_i` during a pass sets `overrun_o`, emits no start pulse, and lets the pass finish. `overrun_o` clears when the next pass starts.
- R8: If `adc_done_i` has not been seen by the ACQ_LIMIT-th cycle of the conversion wait, the pass is abandoned in the next cycle: `sw_o` becomes 000 and `late_o` becomes 1. The first wait cycle counts as 0, default limit 128, and completion in cycle 127 is still accepted.
- R9: The compute stage counts from the cycle after the conversion is accepted (count 0); `ctl_start_o` is high at count 1. If `ctl_done_i` is not seen by count COMP_LIMIT-1 (default 119), the pass is abandoned with `sw_o` = 000 and `late_o` = 1. `late_o` clears when the next pass starts.
- R10: While reset is asserted, and after it, `sw_o` is 000 and `adc_start_o`, `enc_capture_o`, `ctl_start_o`, `overrun_o` and `late_o` are 0; reset forces this at once, even in the middle of a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fs_tick_i | input | 1 | Sampling-rate signal; its rising edge starts a pass |
| adc_start_o | output | 1 | One-cycle start request to the current converter interface |
| enc_capture_o | output | 1 | One-cycle capture strobe to the position interface |
| adc_done_i | input | 1 | Converter reports both phase currents valid |
| adc_ia_i | input | W | Converted phase A current, signed |
| adc_ib_i | input | W | Converted phase B current, signed |
| ia_o | output | W | Registered phase A current for the datapath |
| ib_o | output | W | Registered phase B current for the datapath |
| ic_o | output | W | Derived phase C current, -(A+B) saturated |
| ctl_start_o | output | 1 | One-cycle start to the speed-control datapath |
| ctl_done_i | input | 1 | Datapath result valid |
| sw_cmd_i | input | 3 | Switching commands produced by the datapath |
| sw_o | output | 3 | Registered inverter switching states |
| overrun_o | output | 1 | Sampling edge arrived during a pass |
| late_o | output | 1 | Last pass was abandoned on a budget overrun |

## Verification
Several properties are checked on every cycle. The assertions check that each start pulse is one cycle wide and that a converter start comes only out of idle. They also check that the datapath start follows the current-forming cycle, that the switch outputs move only on an accepted result or an abort, and that an abort always leaves the switches off. An overrun can rise only while a pass is busy, and the budget counter never passes its limit. The bench scenarios cover what the properties cannot. These are the saturated value of the derived current, the exact cycle at which each budget expires, with completion on the last allowed cycle still accepted, a held sampling level producing exactly one pass, an idle done pulse being ignored, and reset clearing the outputs in the middle of a pass.

// File: rtl/sample_seq_pkg.sv
package sample_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_FORM = 2'd2,
    ST_COMP = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_SW = 3;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/seq_tick_edge.sv
module seq_tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/seq_stage_timer.sv
module seq_stage_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire_o = (cnt_q == limit_i);

  always_comb begin
    cnt_en = clear_i | (run_i & ~expire_o);
    if (clear_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= limit_i)); // R9

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/seq_phase_former.sv
module seq_phase_former #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] ia_o,
  output logic [W-1:0] ib_o,
  output logic [W-1:0] ic_o
);

  localparam int unsigned XW = W + 2;
  localparam logic signed [XW-1:0] POS_MAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] NEG_MIN = {3'b111, {(W-1){1'b0}}};

  logic signed [XW-1:0] sum_x;
  logic signed [XW-1:0] neg_x;
  logic        [W-1:0]  ic_d;
  logic        [W-1:0]  ia_q;
  logic        [W-1:0]  ib_q;
  logic        [W-1:0]  ic_q;

  always_comb begin
    sum_x = $signed({{2{a_i[W-1]}}, a_i}) + $signed({{2{b_i[W-1]}}, b_i});
    neg_x = -sum_x;
    if (neg_x > POS_MAX) begin
      ic_d = POS_MAX[W-1:0];
    end else if (neg_x < NEG_MIN) begin
      ic_d = NEG_MIN[W-1:0];
    end else begin
      ic_d = neg_x[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_q <= '0;
      ib_q <= '0;
      ic_q <= '0;
    end else if (load_i) begin
      ia_q <= a_i;
      ib_q <= b_i;
      ic_q <= ic_d;
    end
  end

  assign ia_o = ia_q;
  assign ib_o = ib_q;
  assign ic_o = ic_q;

  AST_PHASE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ia_o == $past(a_i)) && (ib_o == $past(b_i))); // R4

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ic_o)); // R4

endmodule

// File: rtl/sample_seq.sv
module sample_seq
  import sample_seq_pkg::*;
#(
  parameter int unsigned W          = 12,
  parameter int unsigned ACQ_LIMIT  = 128,
  parameter int unsigned COMP_LIMIT = 120
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fs_tick_i,
  output logic         adc_start_o,
  output logic         enc_capture_o,
  input  logic         adc_done_i,
  input  logic [W-1:0] adc_ia_i,
  input  logic [W-1:0] adc_ib_i,
  output logic [W-1:0] ia_o,
  output logic [W-1:0] ib_o,
  output logic [W-1:0] ic_o,
  output logic         ctl_start_o,
  input  logic         ctl_done_i,
  input  logic [2:0]   sw_cmd_i,
  output logic [2:0]   sw_o,
  output logic         overrun_o,
  output logic         late_o
);

  localparam int unsigned MAX_LIMIT = (ACQ_LIMIT > COMP_LIMIT) ? ACQ_LIMIT : COMP_LIMIT;
  localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);
  localparam logic [CW-1:0] ACQ_END  = CW'(ACQ_LIMIT - 1);
  localparam logic [CW-1:0] COMP_END = CW'(COMP_LIMIT - 1);

  logic       rst_n_s;
  logic       tick_rise;
  logic       expire;
  logic [CW-1:0] limit_sel;

  seq_state_e state_q;
  seq_state_e state_d;

  logic start_cyc;
  logic tick_busy;
  logic conv_accept;
  logic conv_abort;
  logic ctl_accept;
  logic ctl_abort;
  logic abort_any;
  logic timer_clear;
  logic timer_run;

  logic                adc_start_q;
  logic                enc_cap_q;
  logic                ctl_start_q;
  logic [NUM_SW-1:0]   sw_q;
  logic [NUM_SW-1:0]   sw_d;
  logic                sw_en;
  logic                ovr_q;
  logic                ovr_d;
  logic                ovr_en;
  logic                late_q;
  logic                late_d;
  logic                late_en;

  seq_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  seq_tick_edge u_tick_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .lvl_i  (fs_tick_i),
    .rise_o (tick_rise)
  );

  assign limit_sel = (state_q == ST_ACQ) ? ACQ_END : COMP_END;

  seq_stage_timer #(
    .CW (CW)
  ) u_stage_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clear_i  (timer_clear),
    .run_i    (timer_run),
    .limit_i  (limit_sel),
    .expire_o (expire)
  );

  seq_phase_former #(
    .W (W)
  ) u_phase_former (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (conv_accept),
    .a_i    (adc_ia_i),
    .b_i    (adc_ib_i),
    .ia_o   (ia_o),
    .ib_o   (ib_o),
    .ic_o   (ic_o)
  );

  // event decode
  always_comb begin
    start_cyc   = (state_q == ST_IDLE) & tick_rise;
    tick_busy   = (state_q != ST_IDLE) & tick_rise;
    conv_accept = (state_q == ST_ACQ)  &  adc_done_i;
    conv_abort  = (state_q == ST_ACQ)  & ~adc_done_i & expire;
    ctl_accept  = (state_q == ST_COMP) &  ctl_done_i;
    ctl_abort   = (state_q == ST_COMP) & ~ctl_done_i & expire;
    abort_any   = conv_abort | ctl_abort;
    timer_clear = start_cyc | conv_accept;
    timer_run   = (state_q != ST_IDLE);
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_cyc) state_d = ST_ACQ;
      ST_ACQ: begin
        if (conv_accept) begin
          state_d = ST_FORM;
        end else if (conv_abort) begin
          state_d = ST_IDLE;
        end
      end
      ST_FORM: state_d = ST_COMP;
      ST_COMP: begin
        if (ctl_accept || ctl_abort) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // output and flag next values
  always_comb begin
    sw_en   = ctl_accept | abort_any;
    sw_d    = abort_any ? '0 : sw_cmd_i;
    ovr_en  = start_cyc | tick_busy;
    ovr_d   = tick_busy;
    late_en = start_cyc | abort_any;
    late_d  = abort_any;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      adc_start_q <= 1'b0;
      enc_cap_q   <= 1'b0;
      ctl_start_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      adc_start_q <= start_cyc;
      enc_cap_q   <= start_cyc;
      ctl_start_q <= (state_q == ST_FORM);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sw_q <= '0;
    end else if (sw_en) begin
      sw_q <= sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovr_q <= 1'b0;
    end else if (ovr_en) begin
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      late_q <= 1'b0;
    end else if (late_en) begin
      late_q <= late_d;
    end
  end

  assign adc_start_o   = adc_start_q;
  assign enc_capture_o = enc_cap_q;
  assign ctl_start_o   = ctl_start_q;
  assign sw_o          = sw_q;
  assign overrun_o     = ovr_q;
  assign late_o        = late_q;

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    adc_start_o |-> ($past(state_q) == ST_IDLE)); // R1

  AST_ADC_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    adc_start_o |=> !adc_start_o); // R2

  AST_ENC_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    enc_capture_o |=> !enc_capture_o); // R2

  AST_CTL_ORDER: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_start_o |-> ($past(state_q) == ST_FORM)); // R3

  AST_CTL_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_start_o |=> !ctl_start_o); // R3

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(sw_o) |-> $past(ctl_accept | abort_any)); // R6

  AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(late_o) |-> (sw_o == '0)); // R8

  AST_OVR_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(overrun_o) |-> ($past(state_q) != ST_IDLE)); // R7

endmodule

// File: tb/sample_seq_bench.sv
`timescale 1ns/1ps
module sample_seq_bench;

  localparam int W = 12;
  localparam int NV = 10;

  // vector table: a, b, expected c, switch command, conversion wait, compute wait, mode
  // mode 0 normal, 1 conversion timeout, 2 compute timeout, 3 overrun tick, 4 held tick
  localparam int TA [NV] = '{100, -500, 2047, -2048, -2048, 0, 1023, 0, 40, 7};
  localparam int TB [NV] = '{200,  120, 2047, -2048,     0, 0,   -1, 0, -40, 8};
  localparam int TC [NV] = '{-300, 380, -2048, 2047,  2047, 0, -1022, 0, 0, -15};
  localparam int TS [NV] = '{5, 2, 7, 1, 6, 0, 3, 0, 4, 0};
  localparam int TW [NV] = '{94, 0, 126, 10, 20, 5, 30, 0, 2, 3};
  localparam int TK [NV] = '{27, 0, 117, 5, 3, 5, 8, 0, 2, 0};
  localparam int TM [NV] = '{0, 0, 0, 3, 4, 0, 0, 1, 0, 2};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         fs_tick_i;
  logic         adc_start_o;
  logic         enc_capture_o;
  logic         adc_done_i;
  logic [W-1:0] adc_ia_i;
  logic [W-1:0] adc_ib_i;
  logic [W-1:0] ia_o;
  logic [W-1:0] ib_o;
  logic [W-1:0] ic_o;
  logic         ctl_start_o;
  logic         ctl_done_i;
  logic [2:0]   sw_cmd_i;
  logic [2:0]   sw_o;
  logic         overrun_o;
  logic         late_o;

  int total = 0;
  int bad = 0;
  int starts_seen = 0;
  int prev_sw = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sample_seq u_sample_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fs_tick_i     (fs_tick_i),
    .adc_start_o   (adc_start_o),
    .enc_capture_o (enc_capture_o),
    .adc_done_i    (adc_done_i),
    .adc_ia_i      (adc_ia_i),
    .adc_ib_i      (adc_ib_i),
    .ia_o          (ia_o),
    .ib_o          (ib_o),
    .ic_o          (ic_o),
    .ctl_start_o   (ctl_start_o),
    .ctl_done_i    (ctl_done_i),
    .sw_cmd_i      (sw_cmd_i),
    .sw_o          (sw_o),
    .overrun_o     (overrun_o),
    .late_o        (late_o)
  );

  always @(posedge clk) begin
    if (adc_start_o) starts_seen <= starts_seen + 1;
  end

  task automatic ceq(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_cycle(input int a, input int b, input int icx, input int sw,
                           input int aw, input int cw, input int mode);
    int s0;
    s0 = starts_seen;
    @(negedge clk); fs_tick_i = 1'b1;
    @(negedge clk);
    ceq("R2 adc_start high", int'(adc_start_o), 1);
    ceq("R2 enc_capture high", int'(enc_capture_o), 1);
    ceq("R7 overrun cleared at start", int'(overrun_o), 0);
    ceq("R9 late cleared at start", int'(late_o), 0);
    @(negedge clk);
    ceq("R2 adc_start one cycle", int'(adc_start_o), 0);
    ceq("R2 enc_capture one cycle", int'(enc_capture_o), 0);
    if (mode != 4) fs_tick_i = 1'b0;
    if (mode == 3) begin
      @(negedge clk); fs_tick_i = 1'b1;
      @(negedge clk); fs_tick_i = 1'b0;
      ceq("R7 overrun set", int'(overrun_o), 1);
      ceq("R7 no second start", int'(adc_start_o), 0);
    end
    if (mode == 1) begin
      repeat (126) @(negedge clk);
      ceq("R8 no abort on last allowed cycle", int'(late_o), 0);
      @(negedge clk);
      ceq("R8 late after conversion budget", int'(late_o), 1);
      ceq("R8 switches off", int'(sw_o), 0);
      prev_sw = 0;
    end else begin
      repeat (aw) @(negedge clk);
      adc_ia_i = W'(a); adc_ib_i = W'(b); adc_done_i = 1'b1;
      @(negedge clk); adc_done_i = 1'b0;
      ceq("R4 ia", int'($signed(ia_o)), a);
      ceq("R4 ib", int'($signed(ib_o)), b);
      ceq("R4 ic derived", int'($signed(ic_o)), icx);
      ceq("R3 ctl_start waits", int'(ctl_start_o), 0);
      @(negedge clk);
      ceq("R3 ctl_start pulse", int'(ctl_start_o), 1);
      @(negedge clk);
      ceq("R3 ctl_start one cycle", int'(ctl_start_o), 0);
      if (mode == 2) begin
        repeat (117) @(negedge clk);
        ceq("R9 no abort on last allowed cycle", int'(late_o), 0);
        ceq("R6 hold during compute", int'(sw_o), prev_sw);
        @(negedge clk);
        ceq("R9 late after compute budget", int'(late_o), 1);
        ceq("R9 switches off", int'(sw_o), 0);
        prev_sw = 0;
      end else begin
        repeat (cw) @(negedge clk);
        ceq("R6 hold during compute", int'(sw_o), prev_sw);
        sw_cmd_i = 3'(sw); ctl_done_i = 1'b1;
        @(negedge clk); ctl_done_i = 1'b0;
        ceq("R5 switches updated", int'(sw_o), sw);
        ceq("R9 late stays low", int'(late_o), 0);
        prev_sw = sw;
      end
    end
    if (mode == 3) ceq("R7 overrun sticky to end", int'(overrun_o), 1);
    repeat (4) @(negedge clk);
    fs_tick_i = 1'b0;
    @(negedge clk);
    ceq("R1 exactly one start per pass", starts_seen - s0, 1);
    ceq("R6 hold after pass", int'(sw_o), prev_sw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fs_tick_i = 1'b0; adc_done_i = 1'b0; ctl_done_i = 1'b0;
    adc_ia_i = '0; adc_ib_i = '0; sw_cmd_i = '0;
    repeat (3) @(negedge clk);
    ceq("R10 reset sw", int'(sw_o), 0);
    ceq("R10 reset adc_start", int'(adc_start_o), 0);
    ceq("R10 reset ctl_start", int'(ctl_start_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ceq("R10 after reset sw", int'(sw_o), 0);
    ceq("R10 after reset overrun", int'(overrun_o), 0);
    ceq("R10 after reset late", int'(late_o), 0);
    ceq("R10 after reset enc", int'(enc_capture_o), 0);

    for (int i = 0; i < NV; i++) begin
      run_cycle(TA[i], TB[i], TC[i], TS[i], TW[i], TK[i], TM[i]);
    end

    // idle done pulse is ignored
    @(negedge clk); sw_cmd_i = 3'b111; ctl_done_i = 1'b1;
    @(negedge clk); ctl_done_i = 1'b0;
    @(negedge clk);
    ceq("R6 idle done ignored", int'(sw_o), prev_sw);
    ceq("R1 idle done starts nothing", int'(adc_start_o), 0);

    // reset in the middle of a pass
    run_cycle(5, 6, -11, 5, 3, 3, 0);
    @(negedge clk); fs_tick_i = 1'b1;
    @(negedge clk); fs_tick_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    ceq("R10 async reset sw", int'(sw_o), 0);
    ceq("R10 async reset late", int'(late_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ceq("R10 idle after reset", int'(ctl_start_o), 0);
    prev_sw = 0;
    run_cycle(-7, 3, 4, 6, 4, 4, 0);

    finish_run();
  end

endmodule